// File: doc/BRIEF.md
# Programmable Parallel I/O Controller

This block gives a CPU three 8-bit general-purpose ports, A, B and C, reached over an 8-bit data bus. Each access uses an active-low select, active-low read and write strobes and a 2-bit address. The 24 port lines fall into two groups of 12. The first group is port A plus the high nibble of port C. The second group is port B plus the low nibble of port C. A mode word written to the control address sets each group's direction and operating mode. A second write format at the same address sets or clears one port C bit without touching the others.

Each port pin has its own input value, output value and output-enable line, so that a pad ring or a bidirectional model can sit outside the block. Handshake sequencing for the strobed and bidirectional modes belongs to a companion block. When a group is in one of those modes, this block releases the lines that the handshake needs.

Writes take effect on the rising clock edge while select and write are both low. Read data is combinational and is valid while select and read are both low.

Top module: `ppi_port_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, the stored mode word is 7'h1B, so a read at address 3 returns 8'h9B. All output-enable lines are 0 and all output latches are 0.
- R2: With `cs_n` high, no write changes any latch or the mode word. `dout` is 8'h00 whenever `cs_n` or `rd_n` is high.
- R3: A write at address 0, 1 or 2 loads the whole latch of port A, B or C. The new value appears on `pa_out`, `pb_out` or `pc_out` one clock edge later, whatever the port's direction.
- R4: A write at address 3 with data bit 7 = 1 stores data bits 6..0 as the mode word. A read at address 3 returns that word with bit 7 forced to 1.
- R5: A mode word write clears all three output latches to 0 at the same edge.
- R6: Direction bits use 1 for input and 0 for output. Bit 4 sets port A, bit 3 the high nibble of C, bit 1 port B and bit 0 the low nibble of C. An output-enable line is 1 exactly when its direction is output and its group's mode leaves the line to this block.
- R7: A read at address 0, 1 or 2 returns the latch value on bits whose output-enable is 1 and the input pin on the other bits.
- R8: A write at address 3 with data bit 7 = 0 sets port C bit `din[3:1]` to `din[0]`. It leaves the other port C bits and the mode word unchanged.
- R9: Mode bits 6..5 give the first group's mode: 00 basic, 01 strobed, 1x bidirectional. Bit 2 gives the second group's mode: 0 basic, 1 strobed. Any non-basic mode of a group makes that group's port C nibble input-only.
- R10: In the bidirectional mode (bit 6 = 1), port A output-enable is 0 and port A reads return the pins. The port A latch is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | 0 port A, 1 port B, 2 port C, 3 control |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not reading |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
Every write lands at the first rising edge that sees the strobe. Latches, the mode word and the output enables are therefore due one edge after the write, and the bench samples them at the next falling edge. Read data has no register in its path, so the bench raises the read strobe in the low clock phase and samples a nanosecond later, before the next rising edge. The sweep covers all 128 mode words and all 16 bit set/reset commands. Expected enables and read data are computed from the mode word bits in the bench.

// File: rtl/ppi_port_ctrl.sv
module ppi_port_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  localparam logic [6:0] MODE_RESET = 7'h1B;

  logic [6:0] mode_q;
  logic [7:0] a_q, b_q, c_q;

  wire wr_en   = !cs_n && !wr_n;
  wire rd_en   = !cs_n && !rd_n;
  wire mode_wr = wr_en && addr == 2'd3 && din[7];
  wire bit_wr  = wr_en && addr == 2'd3 && !din[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RESET;
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (mode_wr) begin
      mode_q <= din[6:0];
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: a_q <= din;
        2'd1: b_q <= din;
        2'd2: c_q <= din;
        default: c_q[din[3:1]] <= din[0];
      endcase
    end
  end

  wire grp_a_basic = mode_q[6:5] == 2'b00;
  wire grp_b_basic = !mode_q[2];

  assign pa_out = a_q;
  assign pb_out = b_q;
  assign pc_out = c_q;
  assign pa_oe  = {8{!mode_q[6] && !mode_q[4]}};
  assign pb_oe  = {8{!mode_q[1]}};
  assign pc_oe  = {{4{grp_a_basic && !mode_q[3]}}, {4{grp_b_basic && !mode_q[0]}}};

  always_comb begin
    dout = 8'h00;
    if (rd_en) begin
      case (addr)
        2'd0: dout = (a_q & pa_oe) | (pa_in & ~pa_oe);
        2'd1: dout = (b_q & pb_oe) | (pb_in & ~pb_oe);
        2'd2: dout = (c_q & pc_oe) | (pc_in & ~pc_oe);
        default: dout = {1'b1, mode_q};
      endcase
    end
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(mode_q));

  p_mode_clears_r5: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00);

  p_bit_keeps_mode_r8: assert property (@(posedge clk) disable iff (rst)
    bit_wr |=> $stable(mode_q) && $stable(pa_out) && $stable(pb_out));

  p_bit_single_r8: assert property (@(posedge clk) disable iff (rst)
    bit_wr |=> $countones(pc_out ^ $past(pc_out)) <= 1);

  p_bidir_release_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && din[6]) |=> pa_oe == 8'h00);
endmodule

// File: tb/sim_ppi_port_ctrl.sv
module sim_ppi_port_ctrl;
  logic clk = 0;
  logic rst = 1;
  logic cs_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic [7:0] pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ppi_port_ctrl u0 (.clk, .rst, .cs_n, .rd_n, .wr_n, .addr, .din, .dout,
    .pa_in, .pa_out, .pa_oe, .pb_in, .pb_out, .pb_oe, .pc_in, .pc_out, .pc_oe);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n = 0);
    @(negedge clk);
    cs_n = sel_n; wr_n = 0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, input logic sel_n = 0);
    @(negedge clk);
    cs_n = sel_n; rd_n = 0; addr = a;
    #1 d = dout;
    cs_n = 1; rd_n = 1;
  endtask

  function automatic logic [7:0] exp_a_oe(input logic [6:0] m);
    return (!m[6] && !m[4]) ? 8'hFF : 8'h00;
  endfunction
  function automatic logic [7:0] exp_b_oe(input logic [6:0] m);
    return m[1] ? 8'h00 : 8'hFF;
  endfunction
  function automatic logic [7:0] exp_c_oe(input logic [6:0] m);
    logic [3:0] hi, lo;
    hi = (m[6:5] == 2'b00 && !m[3]) ? 4'hF : 4'h0;
    lo = (!m[2] && !m[0]) ? 4'hF : 4'h0;
    return {hi, lo};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, cmodel;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(2'd3, r); chk("R1 mode word", r, 8'h9B);
    chk("R1 pa_oe", pa_oe, 8'h00); chk("R1 pb_oe", pb_oe, 8'h00); chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00); chk("R1 pc_out", pc_out, 8'h00);

    // R2 select gating
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h5A);
    wr(2'd0, 8'hFF, 1'b1); chk("R2 gated write A", pa_out, 8'h5A);
    wr(2'd3, 8'h9B, 1'b1); rd(2'd3, r); chk("R2 gated mode write", r, 8'h80);
    rd(2'd0, r, 1'b1); chk("R2 deselected read", dout, 8'h00);
    chk("R2 read data idle", r, 8'h00);

    // sweep all mode words: R3 R4 R5 R6 R7 R9 R10
    for (int m = 0; m < 128; m++) begin
      logic [6:0] mw;
      logic [7:0] da, db, dc, ia, ib, ic;
      mw = 7'(m);
      wr(2'd0, 8'hA5); wr(2'd2, 8'h3C);
      wr(2'd3, {1'b1, mw});
      chk("R5 clear A", pa_out, 8'h00); chk("R5 clear B", pb_out, 8'h00); chk("R5 clear C", pc_out, 8'h00);
      rd(2'd3, r); chk("R4 mode readback", r, {1'b1, mw});
      chk("R6 R10 pa_oe", pa_oe, exp_a_oe(mw));
      chk("R6 pb_oe", pb_oe, exp_b_oe(mw));
      chk("R6 R9 pc_oe", pc_oe, exp_c_oe(mw));
      da = 8'(m * 37 + 11); db = 8'(m * 91 + 5); dc = 8'(m * 53 + 200);
      ia = ~da ^ 8'(m); ib = 8'(m * 7) ^ 8'hC3; ic = ~dc;
      pa_in = ia; pb_in = ib; pc_in = ic;
      wr(2'd0, da); wr(2'd1, db); wr(2'd2, dc);
      chk("R3 R10 pa_out", pa_out, da); chk("R3 pb_out", pb_out, db); chk("R3 pc_out", pc_out, dc);
      rd(2'd0, r); chk("R7 R10 read A", r, (da & exp_a_oe(mw)) | (ia & ~exp_a_oe(mw)));
      rd(2'd1, r); chk("R7 read B", r, (db & exp_b_oe(mw)) | (ib & ~exp_b_oe(mw)));
      rd(2'd2, r); chk("R7 R9 read C", r, (dc & exp_c_oe(mw)) | (ic & ~exp_c_oe(mw)));
    end

    // R8 bit set/reset sweep
    wr(2'd3, 8'h80);
    cmodel = 8'h00;
    wr(2'd2, 8'h00);
    for (int v = 1; v >= 0; v--) begin
      for (int i = 0; i < 8; i++) begin
        wr(2'd3, {4'b0000, 3'(i), 1'(v)});
        cmodel[i] = 1'(v);
        chk("R8 bit set/reset", pc_out, cmodel);
        chk("R8 port A untouched", pa_out, 8'h00);
      end
    end
    wr(2'd2, 8'h96); cmodel = 8'h96;
    wr(2'd3, 8'h7D); cmodel[6] = 1'b1;
    chk("R8 high bits ignored", pc_out, cmodel);
    rd(2'd3, r); chk("R8 mode word kept", r, 8'h80);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule